// File: doc/BRIEF.md
# Sequential-Write Colour Palette

This block holds a 256-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads the table through a 16-byte register window on a plain 32-bit write bus (valid, byte offset, data). One write picks the entry to load. Each later write to the colour data register fills the next component of that entry, first red, then green, then blue. After blue the block moves to the next entry without further help, so a whole palette loads as one stream of colour writes after a single index write.

A separate lookup port serves the scanout path. It maps an 8-bit pixel code to a 24-bit RGB word with no clock in between. Reads of the register window return zero. A synchronous, active-high reset loads black into every entry except the last one, which is white, and clears the index and the component phase.

Top module: `seq_palette_dac`

## Requirements
- R1: While reset is high at a clock edge, every entry becomes 0x000000 except entry 255, which becomes 0xFFFFFF. The write index becomes 0 and the phase becomes red.
- R2: A write at byte offset 0 loads the write index from data bits 31:24 and returns the phase to red, even in the middle of an entry.
- R3: A write at byte offset 4 stores data bits 31:24 into one component of the indexed entry. The phase picks the component: red, then green, then blue. On the lookup output, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R4: The blue write moves the write index up by one, from 255 back to 0, and returns the phase to red.
- R5: A write at any byte offset other than 0 and 4 changes no entry, no index and no phase.
- R6: The register read data output is always zero.
- R7: The lookup output is combinational in the pixel code. A component write shows on it from the clock edge that takes the write.
- R8: If a write and a lookup target the same entry in the same cycle, the lookup shows the old value during that cycle.
- R9: A write strobe that is high while reset is high has no effect.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Register write strobe |
| wrAddr | input | 4 | Byte offset within the register window |
| wrData | input | 32 | Write data; bits 31:24 carry the value |
| regRdData | output | 32 | Register read data, always zero |
| pixIndex | input | 8 | Pixel code to look up |
| pixRgb | output | 24 | Colour of the looked-up entry: red, green, blue from the top |

## Verification
The assertions assume that reset is high at the first clock edge and that the write inputs are not X whenever wrValid is high. The R7 assertion looks only at cycles where the pixel code stays the same across the edge. The bench keeps to these limits: it holds reset from time zero, and it always drives the offset and data to known values, including in the random phase where it mixes index writes, colour writes and writes to unused offsets. It also drives writes while reset is high on purpose, to show that they are dropped.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int IDX_W    = 8;
  localparam int COMP_W   = 8;
  localparam int NUM_COMP = 3;

  // The colour data register walks these phases in order
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2,
    PH_BAD = 2'd3
  } phase_e;

  // Strobes from control to the table
  typedef struct packed {
    logic               wrEn;
    logic [IDX_W-1:0]   wrIdx;
    phase_e             comp;
    logic [COMP_W-1:0]  wrVal;
  } clut_strobe_t;

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int INDEX_OFF = 0,
  parameter int DATA_OFF  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output clut_strobe_t      strobe,
  output logic [IDX_W-1:0]  curIndex,
  output phase_e            curPhase
);

  localparam int LOW_W = DATA_W - COMP_W;

  logic               hitIndex;
  logic               hitData;
  logic [COMP_W-1:0]  fieldVal;
  logic [IDX_W-1:0]   fieldIdx;
  logic               unusedLowBits;

  assign hitIndex = wrValid && !rst && (wrAddr == ADDR_W'(INDEX_OFF));
  assign hitData  = wrValid && !rst && (wrAddr == ADDR_W'(DATA_OFF));
  assign fieldVal = wrData[DATA_W-1 -: COMP_W];
  assign fieldIdx = wrData[DATA_W-1 -: IDX_W];
  assign unusedLowBits = ^wrData[LOW_W-1:0];

  // Component write strobe for the table
  always_comb begin
    strobe = '0;
    if (hitData && curPhase != PH_BAD) begin
      strobe.wrEn  = 1'b1;
      strobe.wrIdx = curIndex;
      strobe.comp  = curPhase;
      strobe.wrVal = fieldVal;
    end
  end

  // Index and phase sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      curIndex <= '0;
      curPhase <= PH_RED;
    end else if (hitIndex) begin
      curIndex <= fieldIdx;
      curPhase <= PH_RED;
    end else if (hitData) begin
      case (curPhase)
        PH_RED:  curPhase <= PH_GRN;
        PH_GRN:  curPhase <= PH_BLU;
        PH_BLU: begin
          curIndex <= curIndex + 1'b1;
          curPhase <= PH_RED;
        end
        default: curPhase <= PH_RED;
      endcase
    end
  end

endmodule

// File: rtl/clut_bank.sv
module clut_bank
  import clut_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int COMP_SEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  clut_strobe_t      strobe,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [COMP_W-1:0] rdVal
);

  logic [COMP_W-1:0] mem [ENTRIES];
  logic              selMe;

  assign selMe = strobe.wrEn && (strobe.comp == phase_e'(COMP_SEL));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        mem[e] <= (e == ENTRIES - 1) ? '1 : '0;
      end
    end else if (selMe) begin
      mem[strobe.wrIdx] <= strobe.wrVal;
    end
  end

  assign rdVal = mem[rdIdx];

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  clut_strobe_t               strobe,
  input  logic [IDX_W-1:0]           rdIdx,
  output logic [NUM_COMP*COMP_W-1:0] rdRgb
);

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
    clut_bank #(
      .ENTRIES (ENTRIES),
      .COMP_SEL(c)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .strobe(strobe),
      .rdIdx (rdIdx),
      .rdVal (rdRgb[(NUM_COMP-1-c)*COMP_W +: COMP_W])
    );
  end

endmodule

// File: rtl/seq_palette_dac.sv
module seq_palette_dac
  import clut_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrValid,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [IDX_W-1:0]           pixIndex,
  output logic [NUM_COMP*COMP_W-1:0] pixRgb
);

  clut_strobe_t     strobe;
  logic [IDX_W-1:0] curIndex;
  phase_e           curPhase;

  clut_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .curIndex(curIndex),
    .curPhase(curPhase)
  );

  clut_store #(
    .ENTRIES(ENTRIES)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .rdIdx (pixIndex),
    .rdRgb (pixRgb)
  );

  assign regRdData = '0;

endmodule

// File: rtl/seq_palette_dac_checks.sv
module seq_palette_dac_checks #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int RGB_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [IDX_W-1:0]  pixIndex,
  input logic [RGB_W-1:0]  pixRgb,
  input logic [IDX_W-1:0]  curIndex,
  input logic [1:0]        curPhase
);

  // R1 and R9: reset clears sequencing state whatever the write strobe does
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (curIndex == '0 && curPhase == 2'd0));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wrValid && wrAddr == ADDR_W'(0)) |=>
      (curIndex == $past(wrData[DATA_W-1 -: IDX_W]) && curPhase == 2'd0));

  assert_blue_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (wrValid && wrAddr == ADDR_W'(4) && curPhase == 2'd2) |=>
      (curIndex == IDX_W'($past(curIndex) + 1'b1) && curPhase == 2'd0));

  assert_other_offset_R5: assert property (@(posedge clk) disable iff (rst)
    (wrValid && wrAddr != ADDR_W'(0) && wrAddr != ADDR_W'(4)) |=>
      (curIndex == $past(curIndex) && curPhase == $past(curPhase)));

  assert_write_visible_R7: assert property (@(posedge clk) disable iff (rst)
    (wrValid && wrAddr == ADDR_W'(4) && curPhase == 2'd0 && pixIndex == curIndex) |=>
      (!$stable(pixIndex) || pixRgb[RGB_W-1 -: 8] == $past(wrData[DATA_W-1 -: 8])));

endmodule

bind seq_palette_dac seq_palette_dac_checks #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_checks (
  .clk     (clk),
  .rst     (rst),
  .wrValid (wrValid),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .pixIndex(pixIndex),
  .pixRgb  (pixRgb),
  .curIndex(curIndex),
  .curPhase(curPhase)
);

// File: tb/seq_palette_dac_tb.sv
module seq_palette_dac_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrValid = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  pixIndex = '0;
  logic [31:0] regRdData;
  logic [23:0] pixRgb;

  always #2 clk = ~clk;   // 250 MHz

  seq_palette_dac u_dut (
    .clk      (clk),
    .rst      (rst),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .regRdData(regRdData),
    .pixIndex (pixIndex),
    .pixRgb   (pixRgb)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string curTag = "R1";

  // Behavioural reference
  int mR[256];
  int mG[256];
  int mB[256];
  int mIdx;
  int mPh;

  task automatic modelReset();
    for (int e = 0; e < 256; e++) begin
      mR[e] = (e == 255) ? 255 : 0;
      mG[e] = (e == 255) ? 255 : 0;
      mB[e] = (e == 255) ? 255 : 0;
    end
    mIdx = 0;
    mPh  = 0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (rst) begin
      modelReset();
    end else if (wrValid) begin
      if (wrAddr == 4'd0) begin
        mIdx = int'(wrData[31:24]);
        mPh  = 0;
      end else if (wrAddr == 4'd4) begin
        case (mPh)
          0: begin mR[mIdx] = int'(wrData[31:24]); mPh = 1; end
          1: begin mG[mIdx] = int'(wrData[31:24]); mPh = 2; end
          default: begin
            mB[mIdx] = int'(wrData[31:24]);
            mIdx = (mIdx + 1) % 256;
            mPh = 0;
          end
        endcase
      end
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      check(curTag, {8'h0, pixRgb},
            {8'h0, mR[pixIndex][7:0], mG[pixIndex][7:0], mB[pixIndex][7:0]});
      check("R6", regRdData, 32'h0);
    end
  end

  task automatic drive(logic [3:0] a, logic [7:0] v);
    @(posedge clk); #1;
    wrValid = 1'b1;
    wrAddr  = a;
    wrData  = {v, 24'h5A5A5A};
  endtask

  task automatic look(logic [7:0] idx, logic [23:0] exp, string tag);
    @(posedge clk); #1;
    wrValid  = 1'b0;
    pixIndex = idx;
    @(negedge clk);
    check(tag, {8'h0, pixRgb}, {8'h0, exp});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset contents
    curTag = "R1";
    look(8'd0,   24'h000000, "R1");
    look(8'd255, 24'hFFFFFF, "R1");
    look(8'd128, 24'h000000, "R1");
    for (int i = 0; i < 256; i++) look(8'(i), (i == 255) ? 24'hFFFFFF : 24'h0, "R1");

    // R3: red, green, blue sequence
    curTag = "R3";
    drive(4'd0, 8'd10);
    drive(4'd4, 8'h11);
    drive(4'd4, 8'h22);
    drive(4'd4, 8'h33);
    look(8'd10, 24'h112233, "R3");
    drive(4'd4, 8'h44);
    look(8'd11, 24'h440000, "R4");

    // R2: index write mid-entry restarts at red
    curTag = "R2";
    drive(4'd0, 8'd20);
    drive(4'd4, 8'hAA);
    drive(4'd0, 8'd20);
    drive(4'd4, 8'hBB);
    drive(4'd4, 8'hCC);
    drive(4'd4, 8'hDD);
    look(8'd20, 24'hBBCCDD, "R2");

    // R4: wrap from 255 to 0
    curTag = "R4";
    drive(4'd0, 8'd255);
    drive(4'd4, 8'h01);
    drive(4'd4, 8'h02);
    drive(4'd4, 8'h03);
    drive(4'd4, 8'h77);
    look(8'd255, 24'h010203, "R4");
    look(8'd0,   24'h770000, "R4");

    // R5: other offsets ignored
    curTag = "R5";
    drive(4'd0, 8'd30);
    drive(4'd4, 8'h61);
    drive(4'd8, 8'hE1);
    drive(4'd12, 8'hE2);
    drive(4'd5, 8'hE3);
    drive(4'd1, 8'hE4);
    look(8'd30, 24'h610000, "R5");
    drive(4'd4, 8'h62);
    drive(4'd4, 8'h63);
    look(8'd30, 24'h616263, "R5");

    // R9: writes during reset dropped, reset restores contents (R1)
    curTag = "R9";
    @(posedge clk); #1;
    rst = 1'b1; wrValid = 1'b1; wrAddr = 4'd0; wrData = 32'h40000000;
    @(posedge clk); #1;
    wrAddr = 4'd4; wrData = 32'h99000000;
    @(posedge clk); #1;
    rst = 1'b0; wrValid = 1'b0;
    look(8'd10, 24'h000000, "R1");
    look(8'd255, 24'hFFFFFF, "R1");
    drive(4'd4, 8'h55);
    look(8'd0,  24'h550000, "R9");
    look(8'd64, 24'h000000, "R9");

    // R8 then R7: same-entry write and lookup
    curTag = "R8";
    drive(4'd0, 8'd40);
    @(posedge clk); #1;
    wrValid = 1'b1; wrAddr = 4'd4; wrData = 32'h9A000000; pixIndex = 8'd40;
    @(negedge clk);
    check("R8", {8'h0, pixRgb}, 32'h0);
    @(posedge clk); #1;
    wrValid = 1'b0;
    @(negedge clk);
    check("R7", {8'h0, pixRgb}, 32'h009A0000);

    // Mixed random stream against the reference
    curTag = "R3";
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      wrValid  = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 5))
        0:       wrAddr = 4'd0;
        1:       wrAddr = 4'($urandom_range(0, 15));
        default: wrAddr = 4'd4;
      endcase
      wrData   = $urandom();
      pixIndex = 8'($urandom_range(0, 255));
    end
    @(posedge clk); #1;
    wrValid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule